// File: doc/BRIEF.md
# Address Shift Distance Calculator

This unit sits beside the address register of a random access scan controller. The address register only moves by shifting left, one new bit entering at the least significant end on each shift. Before a target flip-flop address can be selected, the controller has to know how many shifts are needed and which bits to feed in. The unit holds that register itself, so the starting contents are whatever the previous transition left behind. After reset the register is all zeros.

At any moment the cost output gives the fewest left shifts that turn the current register contents into the presented target. It works by finding the largest overlap between the tail of the current value and the head of the target. The cost is combinational, so a scheduler can weigh candidate targets one per cycle. When `start` is pulsed while the unit is idle, a small sequencer takes a copy of the target and its cost. It then emits the missing low-order target bits one per cycle, most significant first, and shifts each one into the register. It pulses `done` once the register matches. A full-width reload is the worst case, and its cost equals the register width.

Top module: `asd_shift_distance`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `addr_q` is all zeros and `busy`, `shift_valid` and `done` are low.
- R2: `cost` is combinational from `addr_q` and `target`. It is the smallest k in 0..N for which bits [N-1-k:0] of `addr_q` equal bits [N-1:k] of `target`, so k is 0 exactly when the two are equal. For example, with N=4 the transition 0101 to 1011 costs 1.
- R3: `cost` never exceeds N. It reaches N when no suffix of `addr_q` matches a prefix of `target`; 1011 to 0100 is one such case. The port is ceil(log2(N+1)) bits wide.
- R4: A `start` taken while idle with nonzero cost k makes `shift_valid` high for exactly the k following cycles. During those cycles `shift_bit` carries `target` bits k-1 down to 0, in that order, with `busy` high.
- R5: Each clock edge with `shift_valid` high moves `addr_q` left by one place, with `shift_bit` entering at bit 0. When `done` is high, `addr_q` equals the target that was captured.
- R6: `done` is high for one cycle, namely the cycle after the last `shift_valid` cycle. For a start with cost 0, `done` is high in the cycle right after the start, with no `shift_valid` cycle at all.
- R7: A `start` that arrives while `busy` is high is ignored. The bits emitted and the final `addr_q` belong to the transition already in progress.
- R8: A `start` in the cycle where `done` is high is accepted. Its cost is taken from the register contents left by the transition that just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| target | input | N | Address the register should reach |
| start | input | 1 | Capture `target` and begin shifting when idle |
| cost | output | ceil(log2(N+1)) | Minimum left shifts from `addr_q` to `target` |
| addr_q | output | N | Current address register contents |
| busy | output | 1 | Sequencer is emitting bits |
| shift_valid | output | 1 | `shift_bit` is being shifted in this cycle |
| shift_bit | output | 1 | Bit entering the register |
| done | output | 1 | One-cycle pulse when the register matches the captured target |

## Verification
Completion and a new transition can fall in the same cycle. The bench provokes this by raising `start` with a fresh target in exactly the cycle where `done` of the previous transition is high, and it does this for about half of a pseudo-random run of targets. The new cost is judged against a model register that already holds the finished target. The scoreboard then requires the finished transition's done pulse and the new transition's bit stream to appear in sequence, with nothing missing and nothing extra. A cost-zero start that lands on a done cycle must give a second done pulse right after the first.

// File: rtl/asd_pkg.sv
`timescale 1ns/1ps
package asd_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic bitval;
        logic done;
    } seq_out_t;

    function automatic int cost_width(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic int index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/asd_overlap_cost.sv
`timescale 1ns/1ps
module asd_overlap_cost
    import asd_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = cost_width(N)
) (
    input  logic [N-1:0]  cur,
    input  logic [N-1:0]  tgt,
    output logic [CW-1:0] cost
);
    // hit[k]: after k shifts the surviving bits of cur line up with tgt's top
    logic [N:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_overlap
            assign hit[g] = (cur[N-1-g:0] == tgt[N-1:g]);
        end
    endgenerate
    assign hit[N] = 1'b1;

    always_comb begin
        cost = CW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) cost = CW'(i);
        end
    end

endmodule

// File: rtl/asd_addr_reg.sv
`timescale 1ns/1ps
module asd_addr_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [N-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (shift_en) begin
            addr_q <= {addr_q[N-2:0], shift_in};
        end
    end
endmodule

// File: rtl/asd_shift_seq.sv
`timescale 1ns/1ps
module asd_shift_seq
    import asd_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = cost_width(N),
    localparam int IW = index_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [N-1:0]  tgt,
    input  logic [CW-1:0] cost,
    output logic          busy,
    output seq_out_t      out,
    output logic [N-1:0]  job_addr
);
    seq_state_e    state;
    logic [N-1:0]  tgt_q;
    logic [CW-1:0] rem;
    logic          done_q;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            tgt_q  <= '0;
            rem    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        tgt_q <= tgt;
                        rem   <= cost;
                        if (cost == '0) done_q <= 1'b1;
                        else            state  <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    rem <= rem - CW'(1);
                    if (rem == CW'(1)) begin
                        state  <= SEQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        idx        = IW'(rem - CW'(1));
        busy       = (state == SEQ_SHIFT);
        out.valid  = busy;
        out.bitval = busy ? tgt_q[idx] : 1'b0;
        out.done   = done_q;
        job_addr   = tgt_q;
    end

    // R6
    zero_cost_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cost == '0) |=> (out.done && !out.valid));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (tgt_q == $past(tgt_q)));

    // R6
    done_not_shifting_chk: assert property (@(posedge clk) disable iff (rst)
        out.done |-> !out.valid);

endmodule

// File: rtl/asd_shift_distance.sv
`timescale 1ns/1ps
module asd_shift_distance
    import asd_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = cost_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  target,
    input  logic          start,
    output logic [CW-1:0] cost,
    output logic [N-1:0]  addr_q,
    output logic          busy,
    output logic          shift_valid,
    output logic          shift_bit,
    output logic          done
);
    seq_out_t     seq_o;
    logic [N-1:0] job_addr;

    asd_overlap_cost #(.N(N)) u_cost (
        .cur  (addr_q),
        .tgt  (target),
        .cost (cost)
    );

    asd_shift_seq #(.N(N)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tgt      (target),
        .cost     (cost),
        .busy     (busy),
        .out      (seq_o),
        .job_addr (job_addr)
    );

    asd_addr_reg #(.N(N)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (seq_o.valid),
        .shift_in (seq_o.bitval),
        .addr_q   (addr_q)
    );

    assign shift_valid = seq_o.valid;
    assign shift_bit   = seq_o.bitval;
    assign done        = seq_o.done;

    // R2
    equal_zero_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_q == target) |-> (cost == '0));

    // R3
    cost_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cost <= CW'(N));

    // R5
    done_reached_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (addr_q == job_addr));

endmodule

// File: tb/sim_asd_shift_distance.sv
`timescale 1ns/1ps
module sim_asd_shift_distance;
    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  target = '0;
    logic          start = 1'b0;
    logic [CW-1:0] cost;
    logic [N-1:0]  addr_q;
    logic          busy, shift_valid, shift_bit, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct { bit is_done; bit val; } exp_t;
    exp_t exp_q[$];
    logic [N-1:0] model_reg = '0;

    always #4 clk = ~clk;

    asd_shift_distance #(.N(N)) u0 (
        .clk(clk), .rst(rst), .target(target), .start(start), .cost(cost),
        .addr_q(addr_q), .busy(busy), .shift_valid(shift_valid),
        .shift_bit(shift_bit), .done(done)
    );

    function automatic int model_cost(input logic [N-1:0] c, input logic [N-1:0] t);
        for (int k = 0; k < N; k++) begin
            int unsigned m;
            m = (1 << (N - k)) - 1;
            if ((int'(c) & m) == (int'(t) >> k)) return k;
        end
        return N;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pops scoreboard items as the design produces them
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (shift_valid) begin
                if (exp_q.size() == 0 || exp_q[0].is_done) begin
                    check(0, "R4 unexpected shift", int'(shift_bit), -1);
                end else begin
                    check(shift_bit == exp_q[0].val, "R4 shift bit", int'(shift_bit), int'(exp_q[0].val));
                    void'(exp_q.pop_front());
                end
            end
            if (done) begin
                if (exp_q.size() == 0 || !exp_q[0].is_done) begin
                    check(0, "R6 unexpected done", 1, 0);
                end else begin
                    check(1, "R6 done", 1, 1);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // driver: called just after a negedge; leaves the bench at the negedge after start
    task automatic launch(input logic [N-1:0] t, output int k);
        target = t;
        #1;
        k = model_cost(model_reg, t);
        check(int'(cost) == k, "R2 cost", int'(cost), k);
        for (int i = k - 1; i >= 0; i--) exp_q.push_back('{is_done: 1'b0, val: t[i]});
        exp_q.push_back('{is_done: 1'b1, val: 1'b0});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model_reg = t;
    endtask

    // wait through the shifts to the done cycle and check the register
    task automatic finish_job(input int k, input logic [N-1:0] t);
        repeat (k) @(negedge clk);
        check(done == 1'b1, "R6 done timing", int'(done), 1);
        check(addr_q == t, "R5 register reached", int'(addr_q), int'(t));
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        logic [N-1:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(addr_q == '0 && !busy && !shift_valid && !done, "R1 in reset", int'(addr_q), 0);
        rst = 1'b0;
        @(negedge clk);
        check(addr_q == '0 && !busy && !shift_valid && !done, "R1 after reset", int'(addr_q), 0);

        // R4 three-bit transition from zeros
        launch(4'b0101, k);
        check(k == 3, "R2 0000->0101 cost", k, 3);
        finish_job(k, 4'b0101);
        // R8 back-to-back start in the done cycle, one-shift example
        launch(4'b1011, k);
        check(k == 1, "R2 0101->1011 cost", k, 1);
        finish_job(k, 4'b1011);
        // R6 zero cost back-to-back
        launch(4'b1011, k);
        check(k == 0, "R2 equal cost zero", k, 0);
        check(!shift_valid, "R6 no shift for zero cost", int'(shift_valid), 0);
        finish_job(k, 4'b1011);
        @(negedge clk);
        // R3 worst case equals width
        launch(4'b0100, k);
        check(k == N, "R3 full reload cost", k, N);
        check(busy, "R4 busy", int'(busy), 1);
        finish_job(k, 4'b0100);
        @(negedge clk);
        // R7 start while busy is ignored
        launch(4'b0011, k);
        check(k == 2, "R7 setup cost", k, 2);
        target = 4'b1110;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        target = 4'b0011;
        repeat (k - 1) @(negedge clk);
        check(done == 1'b1, "R7 done of original job", int'(done), 1);
        check(addr_q == 4'b0011, "R7 register unaffected", int'(addr_q), 3);
        @(negedge clk);
        check(!busy && !done, "R7 no second job", int'(busy), 0);

        // pseudo-random run, half of it back-to-back (R8)
        lfsr = 4'b1001;
        for (int j = 0; j < 24; j++) begin
            lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
            launch(lfsr ^ N'(j), k);
            finish_job(k, lfsr ^ N'(j));
            if (j % 2 == 1) @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule